// File: doc/BRIEF.md
# Multithreaded Stage Skid Controller

This block holds the control state and instruction buffering for one stage of an in-order pipeline shared by several hardware threads. Each thread has a status machine and a private queue of instruction tags. A tag is a thread id plus a sequence number. Tags arrive from the upstream stage one per cycle over a valid/ready handshake. They leave one per cycle over a second valid/ready handshake toward the downstream stage. All threads draw on one shared pool of skid capacity.

Per-thread block and unblock flags come back from the downstream stage, and each thread also has a resource-stall input. Either source holds that thread in a stalled state. The block raises its own one-cycle block and unblock flags toward the upstream stage.

Two squash channels can name a thread and a sequence number. A squash discards that thread's tags that are younger than the number, and keeps the older ones.

Back-pressure rules:
- An upstream tag is taken on any cycle where `in_valid` and `in_ready` are both high.
- `in_ready` depends only on the shared free count.
- A downstream tag moves when `out_valid` and `out_ready` are both high.
- `out_valid` can fall without a transfer if a stall or squash reaches the offered thread in that cycle.

Top module: `skid_stage_ctrl`

## Requirements
- R1: After reset, every thread status is Idle, `free_slots` equals CAP, `in_ready` is 1, `out_valid` is 0, and no upstream flag is raised. `thr_state` holds 3 bits per thread, with thread t at bits [3t+2:3t]. The encodings are Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4.
- R2: `free_slots` equals CAP minus the tags held across all threads, and `in_ready` is high exactly when that count is at least one. An offered tag is not taken while `in_ready` is low.
- R3: A tag accepted with `in_kill` high is consumed but never stored and never emitted.
- R4: Each thread's tags leave in arrival order (sequence numbers rise per thread), at most one per cycle. A tag is offered only from a thread that meets all of these conditions:
  - its status is Idle, Running or Unblocking;
  - it is not stalled;
  - it is not squashed this cycle.
  Among such threads, the lowest index wins.
- R5: A thread is stalled while its downstream stall bit or its `res_stall` input is set. `dn_block` sets the bit and `dn_unblock` clears it; when both arrive together, the clear wins. A stalled thread goes to Blocked.
- R6: On entering a stall, `up_block` for that thread pulses for one cycle, one cycle later. The pulse happens only if the thread was neither Blocked nor Unblocking.
- R7: An Idle or Running thread that starts a cycle with a held tag and does not send it goes to Blocked, and raises no `up_block`. An Idle thread that sends a tag becomes Running.
- R8: A Blocked thread with no stall moves to Unblocking. An Unblocking thread drains its queue. When the queue is empty, the thread moves to Running and pulses `up_unblock` for one cycle.
- R9: A squash for a thread removes every held tag of that thread whose sequence number is greater than the squash number, and keeps tags that are equal or smaller. An incoming tag of that thread that is younger than the squash number is dropped in the same cycle. The thread enters Squashing unless it is stalled.
- R10: On the cycle after Squashing, the thread goes to Unblocking if it still holds tags, otherwise to Running.
- R11: When both squash channels name the same thread in one cycle, the smaller sequence number is applied and the other is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream tag offered |
| in_ready | output | 1 | Shared pool has room |
| in_tid | input | TID_W | Thread of the offered tag |
| in_seq | input | SEQ_W | Sequence number of the offered tag |
| in_kill | input | 1 | Offered tag is already squashed |
| out_valid | output | 1 | Tag offered downstream |
| out_ready | input | 1 | Downstream takes the tag |
| out_tid | output | TID_W | Thread of the outgoing tag |
| out_seq | output | SEQ_W | Sequence number of the outgoing tag |
| dn_block | input | NUM_THR | Per-thread block from the next stage |
| dn_unblock | input | NUM_THR | Per-thread unblock from the next stage |
| res_stall | input | NUM_THR | Per-thread outstanding resource stall |
| sqa_valid | input | 1 | Squash channel A active |
| sqa_tid | input | TID_W | Squash channel A thread |
| sqa_seq | input | SEQ_W | Squash channel A sequence number |
| sqb_valid | input | 1 | Squash channel B active |
| sqb_tid | input | TID_W | Squash channel B thread |
| sqb_seq | input | SEQ_W | Squash channel B sequence number |
| up_block | output | NUM_THR | One-cycle block flag to the previous stage |
| up_unblock | output | NUM_THR | One-cycle unblock flag to the previous stage |
| free_slots | output | CNT_W | Free entries in the shared pool |
| thr_state | output | 3*NUM_THR | Per-thread status codes |

## Verification
A squash and an upstream push for the same thread can land in the same cycle. Both squash channels can also target that thread at once.

The bench fills thread 0 to one entry short of capacity, with downstream held off. In a single cycle it then offers a younger tag for thread 0 and fires both squash channels at thread 0 with different numbers. The result is judged from the free count: only the older squash number with the incoming tag dropped leaves exactly two entries. The queue is then drained, and the bench requires that exactly the two retained tags appear, in order.

// File: rtl/skid_stage_pkg.sv
package skid_stage_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_BLK  = 3'd2,
    ST_UNB  = 3'd3,
    ST_SQ   = 3'd4
  } thr_st_e;
endpackage

// File: rtl/skid_sq_merge.sv
// Folds the two squash channels into one request per thread, keeping the
// older (smaller) sequence number when both name the same thread.
module skid_sq_merge #(
  parameter int NUM_THR = 2,
  parameter int SEQ_W   = 8,
  parameter int TID_W   = 1
) (
  input  logic             a_valid,
  input  logic [TID_W-1:0] a_tid,
  input  logic [SEQ_W-1:0] a_seq,
  input  logic             b_valid,
  input  logic [TID_W-1:0] b_tid,
  input  logic [SEQ_W-1:0] b_seq,
  output logic [NUM_THR-1:0] hit,
  output logic [SEQ_W-1:0]   seq [NUM_THR]
);
  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    logic hit_a, hit_b;
    assign hit_a  = a_valid && (a_tid == TID_W'(t));
    assign hit_b  = b_valid && (b_tid == TID_W'(t));
    assign hit[t] = hit_a | hit_b;
    always_comb begin
      if (hit_a && hit_b) seq[t] = (a_seq <= b_seq) ? a_seq : b_seq;
      else if (hit_a)     seq[t] = a_seq;
      else                seq[t] = b_seq;
    end
  end
endmodule

// File: rtl/skid_thr_queue.sv
// In-order tag queue for one thread; a squash truncates the younger tail.
module skid_thr_queue #(
  parameter int DEPTH = 4,
  parameter int SEQ_W = 8,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [SEQ_W-1:0] push_seq,
  input  logic             pop,
  input  logic             sq_hit,
  input  logic [SEQ_W-1:0] sq_seq,
  output logic [SEQ_W-1:0] head_seq,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_next
);
  localparam int SLOTS = 2 ** CNT_W;

  logic [SEQ_W-1:0] mem [SLOTS];
  logic [CNT_W-1:0] keep, base;

  always_comb begin
    keep = '0;
    for (int i = 0; i < DEPTH; i++)
      if (CNT_W'(i) < cnt && mem[i] <= sq_seq) keep = keep + CNT_W'(1);
  end

  assign base     = sq_hit ? keep : (cnt - CNT_W'(pop));
  assign cnt_next = base + CNT_W'(push);
  assign head_seq = mem[0];

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_next;
  end

  always_ff @(posedge clk) begin
    if (pop)
      for (int i = 0; i < DEPTH - 1; i++) mem[i] <= mem[i+1];
    if (push && base < CNT_W'(DEPTH)) mem[base] <= push_seq;
  end
endmodule

// File: rtl/skid_thr_ctrl.sv
// Per-thread status machine with downstream stall bit and upstream flags.
module skid_thr_ctrl
  import skid_stage_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dn_block,
  input  logic             dn_unblock,
  input  logic             res_stall,
  input  logic             sq_hit,
  input  logic             pop,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cnt_next,
  output thr_st_e          st,
  output logic             stall_now,
  output logic             up_block,
  output logic             up_unblock
);
  logic    stall_bit, stall_bit_n, blk_n, unb_n;
  thr_st_e st_n;

  always_comb begin
    stall_bit_n = stall_bit;
    if (dn_block)   stall_bit_n = 1'b1;
    if (dn_unblock) stall_bit_n = 1'b0;
  end

  assign stall_now = stall_bit_n | res_stall;

  always_comb begin
    st_n  = st;
    blk_n = 1'b0;
    unb_n = 1'b0;
    if (stall_now) begin
      if (st != ST_BLK && st != ST_UNB) blk_n = 1'b1;
      st_n = ST_BLK;
    end else if (sq_hit) begin
      st_n = ST_SQ;
    end else if (st == ST_BLK) begin
      st_n = ST_UNB;
    end else if (st == ST_SQ) begin
      st_n = (cnt_next != '0) ? ST_UNB : ST_RUN;
    end
    if (!stall_now && !sq_hit) begin
      if (st_n == ST_IDLE || st_n == ST_RUN) begin
        if ((cnt - CNT_W'(pop)) != '0) st_n = ST_BLK;
        else if (pop)                  st_n = ST_RUN;
      end else if (st_n == ST_UNB && cnt_next == '0) begin
        st_n  = ST_RUN;
        unb_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      stall_bit  <= 1'b0;
      up_block   <= 1'b0;
      up_unblock <= 1'b0;
    end else begin
      st         <= st_n;
      stall_bit  <= stall_bit_n;
      up_block   <= blk_n;
      up_unblock <= unb_n;
    end
  end
endmodule

// File: rtl/skid_stage_ctrl.sv
module skid_stage_ctrl
  import skid_stage_pkg::*;
#(
  parameter int NUM_THR = 2,
  parameter int CAP     = 4,
  parameter int SEQ_W   = 8,
  localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
  localparam int CNT_W  = $clog2(CAP + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [TID_W-1:0]       in_tid,
  input  logic [SEQ_W-1:0]       in_seq,
  input  logic                   in_kill,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [TID_W-1:0]       out_tid,
  output logic [SEQ_W-1:0]       out_seq,
  input  logic [NUM_THR-1:0]     dn_block,
  input  logic [NUM_THR-1:0]     dn_unblock,
  input  logic [NUM_THR-1:0]     res_stall,
  input  logic                   sqa_valid,
  input  logic [TID_W-1:0]       sqa_tid,
  input  logic [SEQ_W-1:0]       sqa_seq,
  input  logic                   sqb_valid,
  input  logic [TID_W-1:0]       sqb_tid,
  input  logic [SEQ_W-1:0]       sqb_seq,
  output logic [NUM_THR-1:0]     up_block,
  output logic [NUM_THR-1:0]     up_unblock,
  output logic [CNT_W-1:0]       free_slots,
  output logic [3*NUM_THR-1:0]   thr_state
);
  logic [NUM_THR-1:0] sq_hit, stall_now, elig, pop, push;
  logic [SEQ_W-1:0]   sq_seq   [NUM_THR];
  logic [SEQ_W-1:0]   head_seq [NUM_THR];
  logic [CNT_W-1:0]   cnt      [NUM_THR];
  logic [CNT_W-1:0]   cnt_next [NUM_THR];
  thr_st_e            st       [NUM_THR];
  logic [CNT_W-1:0]   total;
  logic [TID_W-1:0]   sel;
  logic               in_fire;

  assign in_fire = in_valid & in_ready;

  skid_sq_merge #(.NUM_THR(NUM_THR), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_merge (
    .a_valid(sqa_valid), .a_tid(sqa_tid), .a_seq(sqa_seq),
    .b_valid(sqb_valid), .b_tid(sqb_tid), .b_seq(sqb_seq),
    .hit(sq_hit), .seq(sq_seq)
  );

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    assign push[t] = in_fire && !in_kill && (in_tid == TID_W'(t))
                     && !(sq_hit[t] && (in_seq > sq_seq[t]));
    assign elig[t] = (st[t] == ST_IDLE || st[t] == ST_RUN || st[t] == ST_UNB)
                     && (cnt[t] != '0) && !stall_now[t] && !sq_hit[t];
    assign pop[t]  = out_valid && out_ready && (sel == TID_W'(t));
    assign thr_state[3*t +: 3] = st[t];

    skid_thr_queue #(.DEPTH(CAP), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_q (
      .clk(clk), .rst_n(rst_n), .push(push[t]), .push_seq(in_seq),
      .pop(pop[t]), .sq_hit(sq_hit[t]), .sq_seq(sq_seq[t]),
      .head_seq(head_seq[t]), .cnt(cnt[t]), .cnt_next(cnt_next[t])
    );

    skid_thr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .dn_block(dn_block[t]),
      .dn_unblock(dn_unblock[t]), .res_stall(res_stall[t]),
      .sq_hit(sq_hit[t]), .pop(pop[t]), .cnt(cnt[t]),
      .cnt_next(cnt_next[t]), .st(st[t]), .stall_now(stall_now[t]),
      .up_block(up_block[t]), .up_unblock(up_unblock[t])
    );
  end

  always_comb begin
    sel = '0;
    for (int t = NUM_THR - 1; t >= 0; t--)
      if (elig[t]) sel = TID_W'(t);
  end

  always_comb begin
    total = '0;
    for (int t = 0; t < NUM_THR; t++) total = total + cnt[t];
  end

  assign out_valid  = |elig;
  assign out_tid    = sel;
  assign out_seq    = head_seq[sel];
  assign in_ready   = total < CNT_W'(CAP);
  assign free_slots = CNT_W'(CAP) - total;
endmodule

// File: rtl/skid_stage_ctrl_chk.sv
module skid_stage_ctrl_chk #(
  parameter int NUM_THR = 2,
  parameter int CAP     = 4,
  localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
  localparam int CNT_W  = $clog2(CAP + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic [TID_W-1:0]     out_tid,
  input logic [NUM_THR-1:0]   up_block,
  input logic [NUM_THR-1:0]   up_unblock,
  input logic [CNT_W-1:0]     free_slots,
  input logic [3*NUM_THR-1:0] thr_state
);
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_slots <= CNT_W'(CAP));

  // R2
  ready_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> (free_slots == '0));

  // R4
  out_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (thr_state[3*out_tid +: 3] inside {3'd0, 3'd1, 3'd3}));

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    // R6
    blk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_block[t] |=> !up_block[t]);

    // R6
    blk_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_block[t] |-> (thr_state[3*t +: 3] == 3'd2));

    // R8
    unb_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_unblock[t] |-> (thr_state[3*t +: 3] == 3'd1));
  end
endmodule

bind skid_stage_ctrl skid_stage_ctrl_chk #(.NUM_THR(NUM_THR), .CAP(CAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_tid(out_tid), .up_block(up_block),
  .up_unblock(up_unblock), .free_slots(free_slots), .thr_state(thr_state)
);

// File: tb/skid_stage_ctrl_bench.sv
module skid_stage_ctrl_bench;
  localparam int NT = 2;
  localparam int CAPV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_kill = 1'b0, out_ready = 1'b0;
  logic [0:0] in_tid = '0;
  logic [7:0] in_seq = '0;
  logic out_valid, in_ready;
  logic [0:0] out_tid;
  logic [7:0] out_seq;
  logic [NT-1:0] dn_block = '0, dn_unblock = '0, res_stall = '0;
  logic sqa_valid = 1'b0, sqb_valid = 1'b0;
  logic [0:0] sqa_tid = '0, sqb_tid = '0;
  logic [7:0] sqa_seq = '0, sqb_seq = '0;
  logic [NT-1:0] up_block, up_unblock;
  logic [2:0] free_slots;
  logic [3*NT-1:0] thr_state;

  int checks = 0, errs = 0, n_log = 0;
  int last_seq [NT];
  logic [7:0] log_seq [64];
  logic       log_tid [64];
  bit done = 1'b0;

  always #5 clk = ~clk;

  skid_stage_ctrl #(.NUM_THR(NT), .CAP(CAPV), .SEQ_W(8)) u_skid_stage_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tid(in_tid), .in_seq(in_seq), .in_kill(in_kill),
    .out_valid(out_valid), .out_ready(out_ready), .out_tid(out_tid),
    .out_seq(out_seq), .dn_block(dn_block), .dn_unblock(dn_unblock),
    .res_stall(res_stall), .sqa_valid(sqa_valid), .sqa_tid(sqa_tid),
    .sqa_seq(sqa_seq), .sqb_valid(sqb_valid), .sqb_tid(sqb_tid),
    .sqb_seq(sqb_seq), .up_block(up_block), .up_unblock(up_unblock),
    .free_slots(free_slots), .thr_state(thr_state)
  );

  // {kill, tid, seq}
  localparam logic [9:0] VEC [0:7] = '{
    {1'b0, 1'b0, 8'd1}, {1'b0, 1'b1, 8'd1}, {1'b0, 1'b0, 8'd2}, {1'b1, 1'b0, 8'd3},
    {1'b0, 1'b1, 8'd2}, {1'b0, 1'b0, 8'd4}, {1'b1, 1'b1, 8'd3}, {1'b0, 1'b1, 8'd5}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int st_of(input int t);
    return int'(thr_state[3*t +: 3]);
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // R4: per-thread order monitor on every downstream transfer
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      checks++;
      if (int'(out_seq) <= last_seq[out_tid]) begin
        errs++;
        $display("FAIL R4 order thread %0d actual=%0d expected>%0d",
                 out_tid, out_seq, last_seq[out_tid]);
      end
      last_seq[out_tid] = int'(out_seq);
      if (n_log < 64) begin
        log_seq[n_log] = out_seq;
        log_tid[n_log] = out_tid[0];
      end
      n_log++;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    int start, ucount;
    for (int t = 0; t < NT; t++) last_seq[t] = -1;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk(thr_state == '0, "R1 states", int'(thr_state), 0);
    chk(free_slots == 3'(CAPV) && in_ready, "R1 free", int'(free_slots), CAPV);
    chk(!out_valid && up_block == '0 && up_unblock == '0, "R1 outputs",
        int'(out_valid), 0);

    // R3 R4 vector table: push one tag, see it (or not) one cycle later
    out_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin
      in_valid = 1'b1;
      in_kill  = VEC[i][9];
      in_tid   = VEC[i][8];
      in_seq   = VEC[i][7:0];
      step();
      in_valid = 1'b0;
      in_kill  = 1'b0;
      if (VEC[i][9])
        chk(!out_valid, "R3 killed tag dropped", int'(out_valid), 0);
      else
        chk(out_valid && out_tid == VEC[i][8] && out_seq == VEC[i][7:0],
            "R4 pass-through", int'(out_seq), int'(VEC[i][7:0]));
      step();
    end
    chk(st_of(0) == 1 && st_of(1) == 1, "R7 idle to running", int'(thr_state), 9);

    // R2 R7 R8 capacity fill then drain
    out_ready = 1'b0;
    for (int k = 0; k < 4; k++) begin
      in_valid = 1'b1; in_tid = 1'b0; in_seq = 8'(20 + k);
      step();
      chk(free_slots == 3'(3 - k), "R2 free count", int'(free_slots), 3 - k);
      if (k == 1)
        chk(st_of(0) == 2 && up_block[0] == 1'b0, "R7 leftover blocks silently",
            st_of(0), 2);
    end
    chk(!in_ready, "R2 ready low when full", int'(in_ready), 0);
    in_seq = 8'd99;
    step();
    in_valid = 1'b0;
    chk(free_slots == 3'd0, "R2 refused when full", int'(free_slots), 0);
    out_ready = 1'b1;
    start = n_log;
    ucount = 0;
    for (int s = 0; s < 8; s++) begin
      step();
      if (up_unblock[0]) ucount++;
    end
    chk(n_log - start == 4, "R8 drained count", n_log - start, 4);
    for (int k = 0; k < 4; k++)
      chk(log_seq[start+k] == 8'(20 + k) && log_tid[start+k] == 1'b0,
          "R8 drain order", int'(log_seq[start+k]), 20 + k);
    chk(ucount == 1, "R8 one unblock pulse", ucount, 1);
    chk(st_of(0) == 1, "R8 back to running", st_of(0), 1);

    // R5 R6 downstream stall on thread 1
    dn_block[1] = 1'b1;
    step();
    chk(up_block[1] && st_of(1) == 2, "R6 block pulse", int'(up_block[1]), 1);
    dn_block[1] = 1'b0;
    step();
    chk(!up_block[1] && st_of(1) == 2, "R5 stall held", st_of(1), 2);
    dn_block[1] = 1'b1;
    step();
    chk(!up_block[1], "R6 no repeat while blocked", int'(up_block[1]), 0);
    dn_block[1] = 1'b0;
    in_valid = 1'b1; in_tid = 1'b1; in_seq = 8'd10;
    step();
    in_valid = 1'b0;
    chk(!out_valid, "R5 stalled thread not offered", int'(out_valid), 0);
    out_ready = 1'b0;
    dn_block[1] = 1'b1; dn_unblock[1] = 1'b1;
    step();
    dn_block[1] = 1'b0; dn_unblock[1] = 1'b0;
    chk(st_of(1) == 3, "R5 unblock wins", st_of(1), 3);
    chk(out_valid && out_tid == 1'b1 && out_seq == 8'd10, "R8 unblocking offers",
        int'(out_seq), 10);
    out_ready = 1'b1;
    step();
    chk(up_unblock[1] && st_of(1) == 1, "R8 unblock pulse", int'(up_unblock[1]), 1);

    // R5 R6 R8 resource stall on thread 0
    res_stall[0] = 1'b1;
    step();
    chk(up_block[0] && st_of(0) == 2, "R5 resource stall blocks", st_of(0), 2);
    step();
    chk(!up_block[0] && st_of(0) == 2, "R6 single pulse", int'(up_block[0]), 0);
    res_stall[0] = 1'b0;
    step();
    chk(st_of(0) == 1 && up_unblock[0], "R8 empty unblock", st_of(0), 1);

    // R9 R10 R11 squash with concurrent push and double squash
    out_ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      in_valid = 1'b1; in_tid = 1'b0; in_seq = 8'(30 + k);
      step();
    end
    in_seq = 8'd33;
    sqa_valid = 1'b1; sqa_tid = 1'b0; sqa_seq = 8'd35;
    sqb_valid = 1'b1; sqb_tid = 1'b0; sqb_seq = 8'd31;
    step();
    in_valid = 1'b0; sqa_valid = 1'b0; sqb_valid = 1'b0;
    chk(free_slots == 3'd2, "R11 older squash kept", int'(free_slots), 2);
    chk(st_of(0) == 4, "R9 squashing", st_of(0), 4);
    step();
    chk(st_of(0) == 3, "R10 to unblocking", st_of(0), 3);
    out_ready = 1'b1;
    start = n_log;
    repeat (6) step();
    chk(n_log - start == 2, "R9 survivors count", n_log - start, 2);
    chk(log_seq[start] == 8'd30 && log_seq[start+1] == 8'd31,
        "R9 equal number kept", int'(log_seq[start+1]), 31);
    chk(st_of(0) == 1, "R8 running after drain", st_of(0), 1);

    // R10 squash of an empty thread
    sqa_valid = 1'b1; sqa_tid = 1'b1; sqa_seq = 8'd200;
    step();
    sqa_valid = 1'b0;
    chk(st_of(1) == 4, "R9 empty squash", st_of(1), 4);
    step();
    chk(st_of(1) == 1, "R10 to running", st_of(1), 1);

    done = 1'b1;
    summary();
  end
endmodule